// File: doc/BRIEF.md
# Lookup-Table ALU with High-Byte Steering

This block is an arithmetic unit whose every operation, from addition to an 8x8 multiply or a division, is a read of a precomputed table. It forms a 21-bit table address from a 5-bit operation code and two 8-bit operands. It presents that address to a fast shadow memory that answers in the same cycle. On the next clock edge it captures the 16-bit word that comes back.

The low byte of the word is the primary result. The high byte carries either condition bits or the upper half of a wide result, for example the most significant byte of a product. A per-operation control input chooses where that high byte goes: into a flags register or into an upper accumulator. The destination that is not chosen keeps its value.

For operation codes that the division mask marks, bit 15 of the word is a divide-by-zero/exception bit, and it is captured into a separate output. While the table is being reloaded, a busy input blocks all captures and holds the valid output low.

Top module: `alu_lut_unit`

## Requirements
- R1: `tblAddr` always equals {opCode, opA, opB}: opCode in bits 20:16, opA in bits 15:8, opB in bits 7:0.
- R2: When `issue` is high and `tableBusy` is low at a rising edge, `result` shows `tblData[7:0]` of that cycle from that edge onward.
- R3: On such an accepted operation with `routeUpper` low, `flags` loads `tblData[15:8]` and `upperAcc` keeps its value.
- R4: On such an accepted operation with `routeUpper` high, `upperAcc` loads `tblData[15:8]` and `flags` keeps its value.
- R5: With a table whose operation 5 holds the 16-bit product of opA and opB, an accepted operation 5 routed upward leaves the product's low byte in `result` and its high byte in `upperAcc` in the same cycle.
- R6: On an accepted operation whose code has its bit set in `DIV_MASK` (by default codes 6 and 7), `divExc` loads `tblData[15]`. On any other accepted operation `divExc` clears, even when `tblData[15]` is 1.
- R7: While `tableBusy` is high at an edge, `valid` is low after that edge and `result`, `flags`, `upperAcc` and `divExc` do not change.
- R8: `valid` is high for exactly the cycle after each accepted operation. With `issue` low, every held output keeps its value.
- R9: While `rstN` is low, `result`, `flags`, `upperAcc`, `divExc` and `valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Request an operation this cycle |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| opCode | input | 5 | Operation select (32 codes) |
| routeUpper | input | 1 | 1: high byte to upper accumulator, 0: to flags |
| tableBusy | input | 1 | Table is being loaded; blocks captures |
| tblAddr | output | 21 | Table address {opCode, opA, opB} |
| tblData | input | 16 | Table word for `tblAddr`, same cycle |
| result | output | 8 | Captured low byte |
| flags | output | 8 | Flags register |
| upperAcc | output | 8 | Upper accumulator |
| divExc | output | 1 | Divide exception bit |
| valid | output | 1 | A capture happened on the last edge |

## Verification
The embedded properties assume that `issue`, `tableBusy`, `routeUpper` and the operands are settled at every rising edge. They also assume that the table returns the word for the current `tblAddr` within the same cycle, so each capture reflects the operation presented at that edge. The bench meets both assumptions by changing all inputs only on falling edges and by computing `tblData` combinationally from `tblAddr` through its own table function. That function deliberately gives some non-division codes a set bit 15, which exercises the division mask, and it gives a zero divisor to the division codes.

// File: rtl/alu_lut_pkg.sv
package alu_lut_pkg;

  // Strobes handed from the control decoder to the datapath.
  typedef struct packed {
    logic loadResult;
    logic loadFlags;
    logic loadUpper;
    logic divOp;
  } aluStrobes_t;

endpackage

// File: rtl/alu_lut_ctrl.sv
module alu_lut_ctrl
  import alu_lut_pkg::*;
#(
  parameter int OP_W = 5,
  localparam int NUM_OPS = 1 << OP_W,
  parameter logic [NUM_OPS-1:0] DIV_MASK = NUM_OPS'(32'h0000_00C0)
) (
  input  logic            issue,
  input  logic            tableBusy,
  input  logic            routeUpper,
  input  logic [OP_W-1:0] opCode,
  output aluStrobes_t     strobes
);

  logic [NUM_OPS-1:0] opHot;
  logic               accept;

  // One-hot decode of the operation code, masked per code.
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_decode
    assign opHot[k] = (opCode == OP_W'(k)) && DIV_MASK[k];
  end

  assign accept = issue && !tableBusy;

  always_comb begin
    strobes.loadResult = accept;
    strobes.loadFlags  = accept && !routeUpper;
    strobes.loadUpper  = accept && routeUpper;
    strobes.divOp      = |opHot;
  end

endmodule

// File: rtl/alu_lut_dp.sv
module alu_lut_dp
  import alu_lut_pkg::*;
#(
  parameter int OPND_W = 8,
  parameter int OP_W = 5,
  localparam int WORD_W = 2 * OPND_W,
  localparam int ADDR_W = OP_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  output logic [ADDR_W-1:0] tblAddr,
  input  logic [WORD_W-1:0] tblData,
  output logic [OPND_W-1:0] resultQ,
  output logic [OPND_W-1:0] flagsQ,
  output logic [OPND_W-1:0] upperQ,
  output logic              divExcQ,
  output logic              validQ
);

  logic [OPND_W-1:0] loByte;
  logic [OPND_W-1:0] hiByte;

  assign tblAddr = {opCode, opA, opB};
  assign loByte  = tblData[OPND_W-1:0];
  assign hiByte  = tblData[WORD_W-1:OPND_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      divExcQ <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobes.loadResult;
      if (strobes.loadResult) begin
        resultQ <= loByte;
        divExcQ <= strobes.divOp && tblData[WORD_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else if (strobes.loadFlags) flagsQ <= hiByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upperQ <= '0;
    else if (strobes.loadUpper) upperQ <= hiByte;
  end

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadFlags |=> $stable(upperQ));

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadUpper |=> $stable(flagsQ));

  assert_divexc_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadResult && !strobes.divOp) |=> !divExcQ);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadResult |=> ($stable(resultQ) && $stable(divExcQ) && !validQ));

endmodule

// File: rtl/alu_lut_unit.sv
module alu_lut_unit
  import alu_lut_pkg::*;
#(
  parameter int OPND_W = 8,
  parameter int OP_W = 5,
  localparam int WORD_W = 2 * OPND_W,
  localparam int ADDR_W = OP_W + WORD_W,
  localparam int NUM_OPS = 1 << OP_W,
  parameter logic [NUM_OPS-1:0] DIV_MASK = NUM_OPS'(32'h0000_00C0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  input  logic              routeUpper,
  input  logic              tableBusy,
  output logic [ADDR_W-1:0] tblAddr,
  input  logic [WORD_W-1:0] tblData,
  output logic [OPND_W-1:0] result,
  output logic [OPND_W-1:0] flags,
  output logic [OPND_W-1:0] upperAcc,
  output logic              divExc,
  output logic              valid
);

  aluStrobes_t strobes;

  alu_lut_ctrl #(.OP_W(OP_W), .DIV_MASK(DIV_MASK)) u_ctrl (
    .issue     (issue),
    .tableBusy (tableBusy),
    .routeUpper(routeUpper),
    .opCode    (opCode),
    .strobes   (strobes)
  );

  alu_lut_dp #(.OPND_W(OPND_W), .OP_W(OP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .opCode  (opCode),
    .tblAddr (tblAddr),
    .tblData (tblData),
    .resultQ (result),
    .flagsQ  (flags),
    .upperQ  (upperAcc),
    .divExcQ (divExc),
    .validQ  (valid)
  );

  assert_busy_no_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    tableBusy |=> !valid);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    tableBusy |=> ($stable(result) && $stable(flags) && $stable(upperAcc) && $stable(divExc)));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !tableBusy) |=> (valid && result == $past(tblData[OPND_W-1:0])));

endmodule

// File: tb/alu_lut_unit_bench.sv
`timescale 1ns/1ps
module alu_lut_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [4:0]  opCode = '0;
  logic        routeUpper = 1'b0;
  logic        tableBusy = 1'b0;
  logic [20:0] tblAddr;
  logic [15:0] tblData;
  logic [7:0]  result, flags, upperAcc;
  logic        divExc, valid;

  int compared = 0;
  int mismatched = 0;
  string tag = "R9";
  bit done = 1'b0;

  logic [7:0] eRes = '0, eFl = '0, eUp = '0;
  logic       eDiv = 1'b0, eVal = 1'b0;

  always #4 clk = ~clk;

  // Behavioural table contents.
  function automatic logic [15:0] tableFn(input logic [20:0] addr);
    logic [4:0] op;
    logic [7:0] a, b, r;
    logic [8:0] s;
    logic [15:0] w;
    op = addr[20:16]; a = addr[15:8]; b = addr[7:0];
    case (op)
      5'd0: begin s = {1'b0, a} + {1'b0, b}; w = {6'b0, s[7:0] == 8'd0, s[8], s[7:0]}; end
      5'd1: begin s = {1'b0, a} - {1'b0, b}; w = {6'b0, s[7:0] == 8'd0, s[8], s[7:0]}; end
      5'd2: begin r = a & b; w = {6'b0, r == 8'd0, 1'b0, r}; end
      5'd3: begin r = a | b; w = {6'b0, r == 8'd0, 1'b0, r}; end
      5'd4: begin r = a ^ b; w = {6'b0, r == 8'd0, 1'b0, r}; end
      5'd5: w = {8'd0, a} * {8'd0, b};
      5'd6: w = (b == 8'd0) ? 16'h80FF : {8'h00, a / b};
      5'd7: w = (b == 8'd0) ? 16'h8000 : {8'h00, a % b};
      default: w = {b | 8'h80, ~a};
    endcase
    return w;
  endfunction

  assign tblData = tableFn(tblAddr);

  alu_lut_unit u_alu_lut_unit (
    .clk(clk), .rstN(rstN), .issue(issue), .opA(opA), .opB(opB),
    .opCode(opCode), .routeUpper(routeUpper), .tableBusy(tableBusy),
    .tblAddr(tblAddr), .tblData(tblData), .result(result), .flags(flags),
    .upperAcc(upperAcc), .divExc(divExc), .valid(valid)
  );

  // Reference model, updated on each rising edge from the inputs.
  always @(posedge clk or negedge rstN) begin
    logic [15:0] w;
    if (!rstN) begin
      eRes = '0; eFl = '0; eUp = '0; eDiv = 1'b0; eVal = 1'b0;
    end else if (issue && !tableBusy) begin
      w = tableFn({opCode, opA, opB});
      eRes = w[7:0];
      if (routeUpper) eUp = w[15:8];
      else eFl = w[15:8];
      eDiv = (opCode == 5'd6 || opCode == 5'd7) && w[15];
      eVal = 1'b1;
    end else begin
      eVal = 1'b0;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      check("tblAddr R1", tblAddr, {opCode, opA, opB});
      check("result", result, eRes);
      check("flags", flags, eFl);
      check("upperAcc", upperAcc, eUp);
      check("divExc", divExc, eDiv);
      check("valid", valid, eVal);
    end
  end

  task automatic drive(input logic iss, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic up, input logic busy);
    @(negedge clk);
    issue = iss; opCode = op; opA = a; opB = b; routeUpper = up; tableBusy = busy;
  endtask

  initial begin
    // R9: outputs held at zero during reset
    tag = "R9";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2 and R3: arithmetic and logic ops routed to flags
    tag = "R3";
    drive(1, 5'd0, 8'hF0, 8'h20, 0, 0);
    drive(1, 5'd1, 8'h10, 8'h10, 0, 0);
    drive(1, 5'd4, 8'hAA, 8'h55, 0, 0);
    tag = "R2";
    drive(1, 5'd3, 8'h00, 8'h00, 0, 0);
    // R4 and R5: product high byte into upper accumulator, flags held
    tag = "R5";
    drive(1, 5'd5, 8'hFF, 8'hFF, 1, 0);
    drive(1, 5'd5, 8'h12, 8'h34, 1, 0);
    tag = "R4";
    drive(1, 5'd2, 8'h0F, 8'hF3, 1, 0);
    // R6: division, zero divisor, non-division op with bit 15 set
    tag = "R6";
    drive(1, 5'd6, 8'd200, 8'd7, 0, 0);
    drive(1, 5'd6, 8'd9, 8'd0, 0, 0);
    drive(1, 5'd9, 8'h01, 8'h02, 0, 0);
    drive(1, 5'd7, 8'd50, 8'd0, 1, 0);
    drive(1, 5'd7, 8'd50, 8'd8, 1, 0);
    // R7: busy blocks every capture
    tag = "R7";
    drive(1, 5'd6, 8'd1, 8'd0, 0, 1);
    drive(1, 5'd5, 8'h80, 8'h80, 1, 1);
    drive(0, 5'd0, 8'h00, 8'h00, 0, 1);
    // R8: idle cycles hold outputs, valid is a single pulse
    tag = "R8";
    drive(0, 5'd1, 8'h33, 8'h44, 1, 0);
    drive(0, 5'd0, 8'h01, 8'h01, 0, 0);
    drive(1, 5'd0, 8'h01, 8'h01, 0, 0);
    drive(0, 5'd0, 8'h01, 8'h01, 0, 0);
    // Mixed traffic
    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom), 5'($urandom), 8'($urandom), 8'($urandom % 4 == 0 ? 0 : $urandom),
            1'($urandom), ($urandom % 5) == 0);
    end
    // R9: reset in the middle of operation
    tag = "R9";
    drive(1, 5'd5, 8'hEE, 8'hEE, 1, 0);
    @(negedge clk);
    rstN = 1'b0;
    issue = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule